// File: doc/BRIEF.md
# Byte-Order Selectable Transmit Serializer

This block turns packet data held in a buffer into a single serial bit stream. The buffer side delivers words over a valid/ready handshake. Each word carries either one packet byte or two packet bytes. Two configuration bits select the layout. One bit picks single-byte transfers or two-byte words. The other bit, in word mode, picks which half of the word holds the earlier packet byte. Whatever layout the buffer uses, the wire sees the packet bytes in order, and each byte is sent least significant bit first. The first byte on the wire is byte 0 of the destination address, which is followed by the source address, the type/length field and the payload.

A packet begins with the first word accepted while no packet is in progress. At that word the block samples the layout bits and the byte total, and it holds them until the final byte of the packet has been sent. A word is taken only when every bit of the previous word has been shifted out. Bits then leave on consecutive cycles with a strobe. A flag marks the final bit of the packet. Framing, checksums and line coding are handled elsewhere.

Top module: `octet_serializer`

## Requirements
- R1: After reset, in_ready is 1 and both bit_valid and bit_last are 0.
- R2: With cfg_word_mode = 0, each accepted word supplies exactly one packet byte, taken from in_data[7:0], and bits [15:8] have no effect on the output stream.
- R3: With cfg_word_mode = 1 and cfg_hi_lane_first = 0, the even-numbered packet byte of a word is taken from in_data[7:0] and the odd-numbered byte from in_data[15:8].
- R4: With cfg_word_mode = 1 and cfg_hi_lane_first = 1, the even-numbered packet byte of a word is taken from in_data[15:8] and the odd-numbered byte from in_data[7:0].
- R5: Each packet byte is sent as 8 bits on 8 consecutive cycles, least significant bit first, with bit_valid high on each of those cycles. The bytes of a packet leave in packet order, and the first bit appears in the cycle after the word that holds it is accepted.
- R6: in_ready is low while a word is being shifted out (8 cycles for one byte, 16 for two), and it returns high in the cycle after the word's final bit. A word presented while in_ready is low is not taken.
- R7: In word mode with an odd byte total, only the lane holding the earlier byte is used from the final word. That word yields 8 bits, and its other lane has no effect.
- R8: bit_last is high exactly once per packet, together with the last bit of packet byte number byte_total.
- R9: cfg_word_mode, cfg_hi_lane_first and byte_total are sampled only at the first word of a packet. Changing them during a packet has no effect on that packet.
- R10: A byte_total of zero is treated as a one-byte packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_mode | input | 1 | 1: two bytes per word; 0: one byte per word on the low lane |
| cfg_hi_lane_first | input | 1 | In word mode, 1 places the earlier byte on the high lane |
| byte_total | input | CNT_W (12) | Packet length in bytes, sampled at the first word |
| in_data | input | 2*LANE_W (16) | Buffer data word |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | The block can accept a word this cycle |
| bit_out | output | 1 | Serial data bit |
| bit_valid | output | 1 | bit_out carries a packet bit |
| bit_last | output | 1 | bit_out is the final bit of the packet |

## Verification
Several properties are checked on every cycle. The handshake never overlaps with shifting. A burst starts right after an accept. Each shifted bit is the next higher bit of the byte. The sampled lane order stays fixed for the whole packet. The last-bit flag always comes with a valid bit and ends the stream. Two things can only be shown by the bench's sweeps, which run across the three layouts and a range of byte totals, odd and even: that the right lane is chosen for each packet byte, and that the wire order matches packet order. The same holds for unused or changed inputs having no effect and for a zero total.

// File: rtl/osr_pkg.sv
package osr_pkg;

   typedef enum logic [1:0] {
      ORD_NARROW     = 2'd0,
      ORD_LOW_FIRST  = 2'd1,
      ORD_HIGH_FIRST = 2'd2
   } lane_order_t;

   function automatic lane_order_t order_from_cfg(input logic word_mode, input logic hi_first);
      if (!word_mode)
         return ORD_NARROW;
      else if (hi_first)
         return ORD_HIGH_FIRST;
      else
         return ORD_LOW_FIRST;
   endfunction

endpackage

// File: rtl/osr_lane_pick.sv
module osr_lane_pick
   import osr_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic [2*LANE_W-1:0] word,
   input  lane_order_t         order,
   input  logic                second,
   output logic [LANE_W-1:0]   octet
);
   localparam int NLANE = 2;

   logic [LANE_W-1:0] lane [NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane[g] = word[g*LANE_W +: LANE_W];
   end

   always_comb begin
      case (order)
         ORD_NARROW:     octet = lane[0];
         ORD_HIGH_FIRST: octet = second ? lane[0] : lane[1];
         default:        octet = second ? lane[1] : lane[0];
      endcase
   end

endmodule

// File: rtl/osr_shifter.sv
module osr_shifter #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LANE_W-1:0] load_val,
   input  logic              run,
   output logic              ser,
   output logic              at_msb
);
   localparam int IDX_W = (LANE_W > 1) ? $clog2(LANE_W) : 1;
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(LANE_W - 1);

   logic [LANE_W-1:0] shreg;
   logic [IDX_W-1:0]  bidx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         bidx  <= '0;
      end else if (load) begin
         shreg <= load_val;
         bidx  <= '0;
      end else if (run) begin
         shreg <= {1'b0, shreg[LANE_W-1:1]};
         bidx  <= bidx + 1'b1;
      end
   end

   assign ser    = shreg[0];
   assign at_msb = (bidx == IDX_TOP);

   a_r5_next_bit_up: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !at_msb) |=> (ser == $past(shreg[1])));

   a_r5_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bidx == '0));

endmodule

// File: rtl/osr_ctrl.sv
module osr_ctrl
   import osr_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             cfg_word_mode,
   input  logic             cfg_hi_lane_first,
   input  logic [CNT_W-1:0] byte_total,
   input  logic             at_msb,
   output logic             in_ready,
   output logic             accept,
   output logic             busy,
   output logic             load_next,
   output lane_order_t      pick_order,
   output logic             pick_second,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   logic             busy_q;
   logic             lane_q;
   logic             two_q;
   logic [CNT_W-1:0] left_q;
   lane_order_t      ord_q;

   logic             pkt_new;
   logic [CNT_W-1:0] tot_eff;
   logic [CNT_W-1:0] left_at;
   lane_order_t      ord_new;
   logic             byte_end;

   assign pkt_new  = (left_q == '0);
   assign tot_eff  = (byte_total == '0) ? ONE : byte_total;
   assign left_at  = pkt_new ? tot_eff : left_q;
   assign ord_new  = pkt_new ? order_from_cfg(cfg_word_mode, cfg_hi_lane_first) : ord_q;

   assign in_ready  = !busy_q;
   assign accept    = in_valid && !busy_q;
   assign byte_end  = busy_q && at_msb;
   assign load_next = byte_end && two_q && !lane_q;
   assign last      = byte_end && (left_q == ONE);
   assign busy      = busy_q;

   assign pick_order  = accept ? ord_new : ord_q;
   assign pick_second = !accept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         lane_q <= 1'b0;
         two_q  <= 1'b0;
         left_q <= '0;
         ord_q  <= ORD_NARROW;
      end else if (accept) begin
         busy_q <= 1'b1;
         lane_q <= 1'b0;
         two_q  <= (ord_new != ORD_NARROW) && (left_at >= TWO);
         left_q <= left_at;
         ord_q  <= ord_new;
      end else if (byte_end) begin
         left_q <= left_q - ONE;
         if (two_q && !lane_q)
            lane_q <= 1'b1;
         else
            busy_q <= 1'b0;
      end
   end

   a_r9_order_held: assert property (@(posedge clk) disable iff (!rst_n)
      (left_q != '0) |=> $stable(ord_q));

   a_r7_narrow_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && ord_q == ORD_NARROW) |-> !two_q);

   a_r6_word_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && !load_next) |=> in_ready);

endmodule

// File: rtl/octet_serializer.sv
module octet_serializer
   import osr_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int CNT_W  = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_word_mode,
   input  logic                cfg_hi_lane_first,
   input  logic [CNT_W-1:0]    byte_total,
   input  logic [2*LANE_W-1:0] in_data,
   input  logic                in_valid,
   output logic                in_ready,
   output logic                bit_out,
   output logic                bit_valid,
   output logic                bit_last
);
   localparam int WORD_W = 2 * LANE_W;

   initial begin : p_param_chk
      assert (LANE_W >= 2) else $fatal(1, "LANE_W must be at least 2");
      assert (CNT_W >= 2)  else $fatal(1, "CNT_W must be at least 2");
   end

   logic              accept;
   logic              busy;
   logic              load_next;
   logic              pick_second;
   logic              at_msb;
   logic              last;
   lane_order_t       pick_order;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] pick_src;
   logic [LANE_W-1:0] octet;

   always_ff @(posedge clk) begin
      if (!rst_n)
         word_q <= '0;
      else if (accept)
         word_q <= in_data;
   end

   assign pick_src = accept ? in_data : word_q;

   osr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk               (clk),
      .rst_n             (rst_n),
      .in_valid          (in_valid),
      .cfg_word_mode     (cfg_word_mode),
      .cfg_hi_lane_first (cfg_hi_lane_first),
      .byte_total        (byte_total),
      .at_msb            (at_msb),
      .in_ready          (in_ready),
      .accept            (accept),
      .busy              (busy),
      .load_next         (load_next),
      .pick_order        (pick_order),
      .pick_second       (pick_second),
      .last              (last)
   );

   osr_lane_pick #(.LANE_W(LANE_W)) u_pick (
      .word   (pick_src),
      .order  (pick_order),
      .second (pick_second),
      .octet  (octet)
   );

   osr_shifter #(.LANE_W(LANE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept || load_next),
      .load_val (octet),
      .run      (busy),
      .ser      (bit_out),
      .at_msb   (at_msb)
   );

   assign bit_valid = busy;
   assign bit_last  = last;

   a_r6_no_take_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> !in_ready);

   a_r5_burst_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> bit_valid);

   a_r8_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
      bit_last |-> bit_valid);

   a_r8_last_ends_stream: assert property (@(posedge clk) disable iff (!rst_n)
      bit_last |=> (!bit_valid && in_ready));

endmodule

// File: tb/sim_octet_serializer.sv
`timescale 1ns/1ps
module sim_octet_serializer;
   localparam int LANE_W = 8;
   localparam int CNT_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_word_mode = 1'b0;
   logic              cfg_hi_lane_first = 1'b0;
   logic [CNT_W-1:0]  byte_total = '0;
   logic [15:0]       in_data = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic              bit_out;
   logic              bit_valid;
   logic              bit_last;

   int checks = 0;
   int errors = 0;
   int ncap = 0;
   int nlast = 0;
   int lastidx = -1;
   logic cap [0:2047];

   always #10 clk = ~clk;

   octet_serializer #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_word_mode(cfg_word_mode), .cfg_hi_lane_first(cfg_hi_lane_first),
      .byte_total(byte_total), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .bit_out(bit_out), .bit_valid(bit_valid), .bit_last(bit_last)
   );

   always @(negedge clk) begin
      if (rst_n && bit_valid) begin
         if (ncap < 2048) cap[ncap] = bit_out;
         if (bit_last) begin
            nlast++;
            lastidx = ncap;
         end
         ncap++;
      end
   end

   function automatic logic [7:0] pbyte(input int p, input int k);
      return 8'((p * 29 + k * 53 + 7) & 255);
   endfunction

   function automatic logic [7:0] junk(input int k);
      return 8'hA5 ^ 8'(k * 7);
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send_word(input logic [15:0] w, input int lanes, input string req);
      int cnt;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      @(negedge clk);
      in_data = ~w;   // R6: stays offered while shifting, must not be taken
      cnt = 0;
      while (!in_ready) begin
         cnt++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      check(cnt == 8 * lanes, "R6", {req, " ready-low cycles"}, cnt, 8 * lanes);
   endtask

   task automatic send_packet(input int p, input bit wide, input bit hi, input int total,
                              input bit perturb, input string req);
      int n;
      int k;
      int bad;
      int firstbad;
      logic [7:0] b0;
      logic [7:0] b1;
      n = (total == 0) ? 1 : total;
      @(negedge clk);
      cfg_word_mode     = wide;
      cfg_hi_lane_first = hi;
      byte_total        = CNT_W'(total);
      ncap = 0; nlast = 0; lastidx = -1;
      k = 0;
      while (k < n) begin
         b0 = pbyte(p, k);
         if (wide && (k + 1 < n)) begin
            b1 = pbyte(p, k + 1);
            send_word(hi ? {b0, b1} : {b1, b0}, 2, req);
            k += 2;
         end else begin
            b1 = junk(k);
            send_word(wide ? (hi ? {b0, b1} : {b1, b0}) : {b1, b0}, 1, req);
            k += 1;
         end
         if (perturb) begin
            cfg_word_mode     = ~wide;
            cfg_hi_lane_first = ~hi;
            byte_total        = CNT_W'(3);
         end
      end
      repeat (2) @(negedge clk);
      check(ncap == 8 * n, "R5", {req, " bit count"}, ncap, 8 * n);
      bad = 0; firstbad = -1;
      for (int i = 0; i < 8 * n && i < ncap; i++) begin
         if (cap[i] !== pbyte(p, i / 8)[i % 8]) begin
            bad++;
            if (firstbad < 0) firstbad = i;
         end
      end
      check(bad == 0, req, "bit stream mismatches (first index in actual)", firstbad, -1);
      check(nlast == 1, "R8", {req, " last flag count"}, nlast, 1);
      check(lastidx == 8 * n - 1, "R8", {req, " last flag position"}, lastidx, 8 * n - 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
      check(bit_valid == 1'b0, "R1", "bit_valid after reset", int'(bit_valid), 0);
      check(bit_last == 1'b0, "R1", "bit_last after reset", int'(bit_last), 0);

      p = 1;
      for (int n = 1; n <= 9; n++) begin
         send_packet(p, 1'b0, 1'b0, n, 1'b0, "R2"); p++;
         send_packet(p, 1'b0, 1'b1, n, 1'b0, "R2"); p++;
         send_packet(p, 1'b1, 1'b0, n, 1'b0, (n % 2 == 1) ? "R7" : "R3"); p++;
         send_packet(p, 1'b1, 1'b1, n, 1'b0, (n % 2 == 1) ? "R7" : "R4"); p++;
      end
      send_packet(p, 1'b1, 1'b0, 14, 1'b0, "R3"); p++;
      send_packet(p, 1'b1, 1'b1, 15, 1'b0, "R4"); p++;
      send_packet(p, 1'b1, 1'b0, 10, 1'b1, "R9"); p++;
      send_packet(p, 1'b1, 1'b1, 7, 1'b1, "R9"); p++;
      send_packet(p, 1'b0, 1'b0, 6, 1'b1, "R9"); p++;
      send_packet(p, 1'b0, 1'b0, 0, 1'b0, "R10"); p++;
      send_packet(p, 1'b1, 1'b1, 0, 1'b0, "R10"); p++;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule